// File: doc/BRIEF.md
# Dual-Threshold Per-Anode Cluster Finder

The block scans translated 8-bit samples of a detector readout, one anode at a time. For each anode the timebins arrive in order from 0 to the last timebin. The block looks for runs of consecutive timebins whose value is above a low threshold. A run is accepted only when two conditions hold. It must be long enough. It must also contain enough samples above a second, high threshold, and those samples need not be adjacent.

For each accepted run, the first and last timebin are stored as a pair of 10-bit numbers in a list kept for that anode. Each list is capped at a fixed number of pairs. A per-anode count records how many pairs are held. The count and the list entries are read combinationally through a port addressed by anode and entry index. A clear strobe at the start of an event empties every list.

The thresholds and the two qualifier counts come from registers that stay stable for the whole event. Sample ordering is set by the upstream logic.

Top module: `cluster_finder`

## Requirements
- R1: A sample belongs to a run only when it is strictly greater than `thr_lo`. A run is a maximal sequence of consecutive timebins of one anode that meet this condition. A sample equal to `thr_lo` ends a run.
- R2: A run is stored only if its length in timebins is strictly greater than `nseq_lo`.
- R3: A run is stored only if the number of its samples strictly greater than `thr_hi` is strictly greater than `nseq_hi`. These samples need not be consecutive, and a sample equal to `thr_hi` does not count.
- R4: The stored start is the first timebin of the run. This is timebin 0 when the anode's first sample is already above `thr_lo`.
- R5: The stored end is the last timebin of the run. A run still open at timebin MAX_TB (default 127) ends at MAX_TB.
- R6: Accepted runs of an anode are stored in detection order at indices 0, 1, 2 and so on. At `rd_anode`/`rd_idx`, `rd_start` and `rd_end` give the pair. `rd_count` gives the number of stored pairs. Each is visible from the clock edge that captures the closing sample.
- R7: Each anode holds at most 8 pairs. Once `rd_count` reaches 8, further accepted runs of that anode are dropped and the count stays at 8.
- R8: A `clr` pulse sets the count of every anode to 0 after the next clock edge.
- R9: After reset, every anode count reads 0.
- R10: Run state never carries from one anode to the next. Timebin 0 always starts a fresh evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Event-start strobe that empties all lists |
| in_valid | input | 1 | Sample strobe |
| in_anode | input | 8 | Anode of the sample |
| in_tbin | input | 10 | Timebin of the sample |
| in_sample | input | 8 | Translated sample value |
| thr_lo | input | 8 | Low threshold |
| thr_hi | input | 8 | High threshold |
| nseq_lo | input | 10 | Run length must exceed this |
| nseq_hi | input | 10 | High-sample count must exceed this |
| rd_anode | input | 8 | Read anode |
| rd_idx | input | 3 | Read entry index |
| rd_start | output | 10 | Start timebin of the addressed entry |
| rd_end | output | 10 | End timebin of the addressed entry |
| rd_count | output | 4 | Stored pairs for `rd_anode` |

## Verification
The assertions take several things for granted about the inputs:
- Every anode's samples arrive with timebins 0 to MAX_TB, in order and without gaps.
- Thresholds and qualifiers stay constant while samples flow.
- `clr` never coincides with a sample.

The stimulus keeps within these limits:
- Each anode is sent as a complete, ordered sweep.
- Registers change only between sweeps.
- `clr` is pulsed only while `in_valid` is low.

The count-step property also assumes that `rd_anode` is held still. The bench changes it only during read-back, when no samples are written.

// File: rtl/cluster_finder.sv
module cluster_finder #(
  parameter int ANODES = 256,
  parameter int CAP    = 8,
  parameter int TW     = 10,
  parameter int SW     = 8,
  parameter int MAX_TB = 127,
  localparam int AW = $clog2(ANODES),
  localparam int IW = $clog2(CAP),
  localparam int CW = $clog2(CAP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_valid,
  input  logic [AW-1:0] in_anode,
  input  logic [TW-1:0] in_tbin,
  input  logic [SW-1:0] in_sample,
  input  logic [SW-1:0] thr_lo,
  input  logic [SW-1:0] thr_hi,
  input  logic [TW-1:0] nseq_lo,
  input  logic [TW-1:0] nseq_hi,
  input  logic [AW-1:0] rd_anode,
  input  logic [IW-1:0] rd_idx,
  output logic [TW-1:0] rd_start,
  output logic [TW-1:0] rd_end,
  output logic [CW-1:0] rd_count
);

  localparam logic [CW-1:0] CAPV  = CW'(CAP);
  localparam logic [TW-1:0] TLAST = TW'(MAX_TB);

  logic          run_q;
  logic [TW-1:0] start_q, len_q, hic_q;
  logic [CW-1:0] cnt [ANODES];
  logic [2*TW-1:0] mem [ANODES][CAP];

  wire first = (in_tbin == '0);
  wire last  = (in_tbin == TLAST);
  wire cont  = run_q && !first;
  wire above = in_sample > thr_lo;
  wire high  = in_sample > thr_hi;

  wire [TW-1:0] len_n   = cont ? len_q + TW'(1) : TW'(1);
  wire [TW-1:0] hic_n   = (cont ? hic_q : '0) + TW'(high);
  wire [TW-1:0] start_n = cont ? start_q : in_tbin;

  wire close_hi = above && last;
  wire close_lo = !above && cont;

  wire [TW-1:0] c_len   = close_hi ? len_n : len_q;
  wire [TW-1:0] c_hic   = close_hi ? hic_n : hic_q;
  wire [TW-1:0] c_start = close_hi ? start_n : start_q;
  wire [TW-1:0] c_end   = close_hi ? in_tbin : in_tbin - TW'(1);

  wire [CW-1:0] cur_cnt = cnt[in_anode];
  wire wr_en = in_valid && (close_hi || close_lo) &&
               (c_len > nseq_lo) && (c_hic > nseq_hi) && (cur_cnt < CAPV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      start_q <= '0;
      len_q   <= '0;
      hic_q   <= '0;
    end else if (in_valid) begin
      run_q   <= above && !last;
      start_q <= start_n;
      len_q   <= len_n;
      hic_q   <= hic_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ANODES; i++) cnt[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < ANODES; i++) cnt[i] <= '0;
    end else if (wr_en) begin
      cnt[in_anode] <= cur_cnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[in_anode][cur_cnt[IW-1:0]] <= {c_start, c_end};
  end

  assign rd_start = mem[rd_anode][rd_idx][2*TW-1:TW];
  assign rd_end   = mem[rd_anode][rd_idx][TW-1:0];
  assign rd_count = cnt[rd_anode];

endmodule

module cluster_finder_chk #(
  parameter int CAP = 8,
  parameter int TW  = 10,
  parameter int AW  = 8,
  parameter int CW  = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic [AW-1:0] rd_anode,
  input logic [CW-1:0] rd_count,
  input logic          wr_en,
  input logic [TW-1:0] c_start,
  input logic [TW-1:0] c_end,
  input logic [TW-1:0] nseq_lo
);

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_count <= CW'(CAP));

  assert_cap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_count == CW'(CAP) && !clr) |=> (rd_count == CW'(CAP) || !$stable(rd_anode)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rd_count == '0));

  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (!$stable(rd_anode) || rd_count == $past(rd_count) ||
              rd_count == $past(rd_count) + CW'(1)));

  assert_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (c_start <= c_end));

  assert_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((c_end - c_start) >= nseq_lo));

endmodule

bind cluster_finder cluster_finder_chk #(.CAP(CAP), .TW(TW), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .rd_anode(rd_anode), .rd_count(rd_count),
  .wr_en(wr_en), .c_start(c_start), .c_end(c_end), .nseq_lo(nseq_lo)
);

// File: tb/cluster_finder_test.sv
module cluster_finder_test;
  localparam int NTB = 128;

  logic clk = 0, rst_n = 0, clr = 0, in_valid = 0;
  logic [7:0] in_anode = 0, in_sample = 0, thr_lo = 50, thr_hi = 150, rd_anode = 0;
  logic [9:0] in_tbin = 0, nseq_lo = 2, nseq_hi = 1;
  logic [2:0] rd_idx = 0;
  logic [9:0] rd_start, rd_end;
  logic [3:0] rd_count;

  int checks = 0, errors = 0;
  logic [7:0] smp [NTB];
  logic [19:0] exp_q [$];
  int exp_n;

  always #4 clk = ~clk;

  cluster_finder uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fill(input int a, input int b, input logic [7:0] v);
    for (int t = a; t <= b; t++) smp[t] = v;
  endtask

  task automatic clear_smp();
    for (int t = 0; t < NTB; t++) smp[t] = 0;
  endtask

  task automatic model_close(input int st, input int en, input int len, input int hc);
    if (len > nseq_lo && hc > nseq_hi && exp_n < 8) begin
      exp_q.push_back({st[9:0], en[9:0]});
      exp_n++;
    end
  endtask

  task automatic send_anode(input int a);
    bit run = 0;
    int st = 0, len = 0, hc = 0;
    exp_n = 0;
    for (int t = 0; t < NTB; t++) begin
      if (smp[t] > thr_lo) begin
        if (!run) begin run = 1; st = t; len = 0; hc = 0; end
        len++;
        if (smp[t] > thr_hi) hc++;
        if (t == NTB - 1) model_close(st, t, len, hc);
      end else if (run) begin
        model_close(st, t - 1, len, hc);
        run = 0;
      end
    end
    for (int t = 0; t < NTB; t++) begin
      @(negedge clk);
      in_valid = 1; in_anode = a[7:0]; in_tbin = t[9:0]; in_sample = smp[t];
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic check_anode(input int a, input string req);
    logic [19:0] e;
    rd_anode = a[7:0];
    #1;
    chk({req, " count"}, rd_count, exp_n);
    for (int i = 0; i < exp_n; i++) begin
      rd_idx = i[2:0];
      #1;
      e = exp_q.pop_front();
      chk({req, " start"}, rd_start, e[19:10]);
      chk({req, " end"}, rd_end, e[9:0]);
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd_anode = 5; #1;
    chk("R9 reset count", rd_count, 0);
    rd_anode = 200; #1;
    chk("R9 reset count", rd_count, 0);

    clear_smp();
    smp[0] = 200; smp[1] = 60; smp[2] = 200; smp[3] = 60;
    fill(10, 11, 200);
    fill(20, 24, 60); smp[22] = 200;
    fill(30, 35, 60); smp[31] = 150; smp[33] = 150; smp[34] = 151; smp[35] = 151;
    fill(40, 42, 50); fill(44, 46, 180);
    fill(124, 127, 200);
    send_anode(0);
    check_anode(0, "R1 R2 R3 R4 R5");

    clear_smp();
    for (int k = 0; k < 10; k++) fill(k * 10, k * 10 + 3, 200);
    send_anode(1);
    check_anode(1, "R6 R7 R10");

    clear_smp();
    fill(0, 2, 51); smp[0] = 151; smp[2] = 151;
    fill(100, 127, 50);
    send_anode(255);
    check_anode(255, "R1 R3 boundary");

    @(negedge clk);
    nseq_lo = 0; nseq_hi = 0;
    clear_smp();
    smp[5] = 151; smp[7] = 51; smp[9] = 200; smp[10] = 200; smp[127] = 151;
    send_anode(3);
    check_anode(3, "R2 R3 zero qualifiers");

    @(negedge clk);
    clr = 1;
    @(negedge clk);
    clr = 0;
    rd_anode = 0; #1; chk("R8 clear anode 0", rd_count, 0);
    rd_anode = 1; #1; chk("R8 clear anode 1", rd_count, 0);
    rd_anode = 3; #1; chk("R8 clear anode 3", rd_count, 0);

    nseq_lo = 2; nseq_hi = 1;
    clear_smp();
    fill(50, 53, 200);
    send_anode(1);
    check_anode(1, "R6 R8 after clear");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule